// File: doc/BRIEF.md
# PHY Register Access Handshake Master

This block gives on-chip logic read and write access to the 16-bit internal registers of a SerDes PHY. The PHY exposes no address/data bus. Instead it has one 32-bit control word, which this block drives, and one 32-bit status word, which the PHY drives. Every step of a transfer is a four-phase exchange: the master raises one strobe in the control word, waits for the PHY's acknowledge to go high, drops the strobe, and waits for the acknowledge to go low.

A client presents a request made of a direction flag, a 16-bit register address and, for writes, 16-bit data. The request is taken only while `req_ready` is high. Every transfer first runs an address-capture exchange. A read then runs a read-strobe exchange and returns the status data. A write runs a data-capture exchange followed by a write-strobe exchange. The transfer ends with a one-cycle `done` pulse, or with a one-cycle `err` pulse if any acknowledge wait runs out of polls.

The sequencer states are named as follows:
- IDLE is the only state that accepts a request.
- ADDR_SET, ADDR_CAP and ADDR_REL form the address exchange.
- RD_STB and RD_REL form the read exchange.
- DAT_SET, DAT_CAP, DAT_REL, WR_STB, WR_REL and WR_CLR form the write exchange.
- DONE and FAIL each last one cycle.

The transitions are:
- IDLE→ADDR_SET on an accepted request.
- SET→CAP unconditionally.
- CAP→REL and STB→REL when a poll sees the acknowledge high.
- REL→next phase when a poll sees it low. ADDR_REL branches to RD_STB or DAT_SET on the direction flag, RD_REL goes to DONE, DAT_REL goes to WR_STB, WR_REL goes to WR_CLR, and WR_CLR goes to DONE.
- Any wait state goes to FAIL on the last unsuccessful poll.
- DONE and FAIL return to IDLE.

Top module: `phy_ctl_master`

## Requirements
- R1: `req_ready` is high only in IDLE, including right after reset. A request is accepted only when `req_valid` and `req_ready` are both high. Requests presented while busy are ignored and never reach the PHY.
- R2: In the control word, bits 15:0 carry the address or data, bit 16 is the address-capture strobe, bit 17 the data-capture strobe, bit 18 the write strobe and bit 19 the read strobe. Bits 31:20 are always zero, and at most one strobe is set at a time. The control word is zero whenever the block is idle.
- R3: The address exchange drives the address alone for one cycle. It then drives the address with bit 16 set until the acknowledge (status bit 16) is seen high. It then drives the address alone until the acknowledge is seen low.
- R4: A read drives only bit 19 until the acknowledge is high, and captures status bits 15:0 into `rd_data` on that poll. It then drives zero until the acknowledge is low, and then pulses `done`.
- R5: A write drives the data alone for one cycle, then the data with bit 17 set until the acknowledge is high, then the data alone until it is low. It then drives only bit 18 until the acknowledge is high, and the data alone until it is low. It drives zero for one cycle and then pulses `done`.
- R6: In each wait state the acknowledge is polled once every `POLL_GAP` clocks (default 1), starting in the first cycle of that state. After `MAX_POLLS` (default 10) polls without the awaited level, the transfer times out.
- R7: An acknowledge level first seen on the last allowed poll counts as success, not timeout.
- R8: On timeout, `err` pulses for one cycle and `done` does not pulse. The control word is zero from that cycle on, no further strobe is issued for that transfer, and the block returns to IDLE.
- R9: `done` and `err` last exactly one cycle. `rd_data` changes only when a read strobe is acknowledged, and holds its value through writes and failed transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle pulse: transfer completed |
| err | output | 1 | One-cycle pulse: acknowledge wait timed out |
| rd_data | output | 16 | Data returned by the last successful read |
| ctl_word | output | 32 | Control word to the PHY |
| stat_word | input | 32 | Status word from the PHY (bit 16 acknowledge, bits 15:0 data) |

## Verification
In any wait state, the poll that matches the acknowledge and the poll that exhausts the budget can fall in the same cycle: the tenth poll is both the last chance to succeed and the moment of timeout. The bench provokes this with a PHY model whose acknowledge lags its strobe by a programmable number of cycles. A lag of 9 makes the acknowledge arrive on exactly the tenth poll, and the bench expects `done` and correct data. A lag of 10 misses that poll by one cycle, and the bench expects `err`, a zero control word and an unchanged `rd_data`. A stuck-high acknowledge and a PHY that ignores the write strobe push the timeout into later phases.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;

    localparam int REG_W      = 16;
    localparam int WORD_W     = 32;
    localparam int BIT_CAP_A  = 16;
    localparam int BIT_CAP_D  = 17;
    localparam int BIT_WSTB   = 18;
    localparam int BIT_RSTB   = 19;
    localparam int BIT_ACK    = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR_SET,
        ST_ADDR_CAP,
        ST_ADDR_REL,
        ST_RD_STB,
        ST_RD_REL,
        ST_DAT_SET,
        ST_DAT_CAP,
        ST_DAT_REL,
        ST_WR_STB,
        ST_WR_REL,
        ST_WR_CLR,
        ST_DONE,
        ST_FAIL
    } xfer_state_e;

endpackage

// File: rtl/phy_ctl_poll.sv
module phy_ctl_poll #(
    parameter int POLL_GAP  = 1,
    parameter int MAX_POLLS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic poll_tick,
    output logic poll_last
);

    localparam int PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [PW-1:0] LAST_IDX = PW'(MAX_POLLS - 1);

    logic [PW-1:0] used_q;

    generate
        if (POLL_GAP > 1) begin : g_spaced
            localparam int GW = $clog2(POLL_GAP);
            localparam logic [GW-1:0] GAP_END = GW'(POLL_GAP - 1);
            logic [GW-1:0] gap_q;

            always_ff @(posedge clk) begin
                if (!rst_n || restart) begin
                    gap_q <= '0;
                end else if (gap_q == GAP_END) begin
                    gap_q <= '0;
                end else begin
                    gap_q <= gap_q + 1'b1;
                end
            end

            assign poll_tick = (gap_q == '0);
        end else begin : g_every
            assign poll_tick = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            used_q <= '0;
        end else if (poll_tick && (used_q != LAST_IDX)) begin
            used_q <= used_q + 1'b1;
        end
    end

    assign poll_last = (used_q == LAST_IDX);

    assert_poll_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        used_q <= LAST_IDX);

endmodule

// File: rtl/phy_ctl_seq.sv
module phy_ctl_seq
    import phy_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [REG_W-1:0]  req_addr,
    input  logic [REG_W-1:0]  req_wdata,
    input  logic              ack,
    input  logic [REG_W-1:0]  stat_data,
    input  logic              poll_tick,
    input  logic              poll_last,
    output logic              req_ready,
    output logic              done,
    output logic              err,
    output logic [WORD_W-1:0] ctl_word,
    output logic [REG_W-1:0]  rd_data,
    output logic              phase_restart
);

    xfer_state_e state_q, state_d;
    logic [REG_W-1:0] addr_q, data_q, rd_q;
    logic             write_q;
    logic             waiting, want_high, hit, give_up;

    always_comb begin
        waiting   = 1'b0;
        want_high = 1'b0;
        unique case (state_q)
            ST_ADDR_CAP, ST_DAT_CAP, ST_WR_STB, ST_RD_STB: begin
                waiting   = 1'b1;
                want_high = 1'b1;
            end
            ST_ADDR_REL, ST_DAT_REL, ST_WR_REL, ST_RD_REL: begin
                waiting   = 1'b1;
            end
            default: ;
        endcase
    end

    assign hit     = waiting && poll_tick && (ack == want_high);
    assign give_up = waiting && poll_tick && (ack != want_high) && poll_last;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = ST_ADDR_SET;
            ST_ADDR_SET: state_d = ST_ADDR_CAP;
            ST_ADDR_CAP: if (hit) state_d = ST_ADDR_REL;
            ST_ADDR_REL: if (hit) state_d = write_q ? ST_DAT_SET : ST_RD_STB;
            ST_RD_STB:   if (hit) state_d = ST_RD_REL;
            ST_RD_REL:   if (hit) state_d = ST_DONE;
            ST_DAT_SET:  state_d = ST_DAT_CAP;
            ST_DAT_CAP:  if (hit) state_d = ST_DAT_REL;
            ST_DAT_REL:  if (hit) state_d = ST_WR_STB;
            ST_WR_STB:   if (hit) state_d = ST_WR_REL;
            ST_WR_REL:   if (hit) state_d = ST_WR_CLR;
            ST_WR_CLR:   state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            ST_FAIL:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
        if (give_up) state_d = ST_FAIL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
            write_q <= 1'b0;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                addr_q  <= req_addr;
                data_q  <= req_wdata;
                write_q <= req_write;
            end
            if (state_q == ST_RD_STB && hit) begin
                rd_q <= stat_data;
            end
        end
    end

    always_comb begin
        ctl_word  = '0;
        req_ready = 1'b0;
        done      = 1'b0;
        err       = 1'b0;
        unique case (state_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_ADDR_SET: ctl_word[REG_W-1:0] = addr_q;
            ST_ADDR_CAP: begin
                ctl_word[REG_W-1:0] = addr_q;
                ctl_word[BIT_CAP_A] = 1'b1;
            end
            ST_ADDR_REL: ctl_word[REG_W-1:0] = addr_q;
            ST_RD_STB:   ctl_word[BIT_RSTB] = 1'b1;
            ST_RD_REL:   ;
            ST_DAT_SET:  ctl_word[REG_W-1:0] = data_q;
            ST_DAT_CAP: begin
                ctl_word[REG_W-1:0] = data_q;
                ctl_word[BIT_CAP_D] = 1'b1;
            end
            ST_DAT_REL:  ctl_word[REG_W-1:0] = data_q;
            ST_WR_STB:   ctl_word[BIT_WSTB] = 1'b1;
            ST_WR_REL:   ctl_word[REG_W-1:0] = data_q;
            ST_WR_CLR:   ;
            ST_DONE:     done = 1'b1;
            ST_FAIL:     err = 1'b1;
            default:     ;
        endcase
    end

    assign rd_data       = rd_q;
    assign phase_restart = (state_d != state_q);

    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ctl_word[BIT_RSTB:BIT_CAP_A]) <= 1) && (ctl_word[WORD_W-1:20] == '0));

    assert_addr_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (ctl_word == {16'h0, $past(req_addr)}));

    assert_capa_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_word[BIT_CAP_A]) |-> ($past(ctl_word) == {16'h0, ctl_word[REG_W-1:0]}));

    assert_fail_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (ctl_word == '0) && req_ready && !done);

    assert_single_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !err);

    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err || req_ready) |=> $stable(rd_data));

endmodule

// File: rtl/phy_ctl_master.sv
module phy_ctl_master
    import phy_ctl_pkg::*;
#(
    parameter int POLL_GAP  = 1,
    parameter int MAX_POLLS = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    output logic        done,
    output logic        err,
    output logic [15:0] rd_data,
    output logic [31:0] ctl_word,
    input  logic [31:0] stat_word
);

    logic poll_tick, poll_last, phase_restart;

    phy_ctl_poll #(
        .POLL_GAP  (POLL_GAP),
        .MAX_POLLS (MAX_POLLS)
    ) poll_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (phase_restart),
        .poll_tick (poll_tick),
        .poll_last (poll_last)
    );

    phy_ctl_seq seq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .ack           (stat_word[BIT_ACK]),
        .stat_data     (stat_word[REG_W-1:0]),
        .poll_tick     (poll_tick),
        .poll_last     (poll_last),
        .req_ready     (req_ready),
        .done          (done),
        .err           (err),
        .ctl_word      (ctl_word),
        .rd_data       (rd_data),
        .phase_restart (phase_restart)
    );

endmodule

// File: tb/phy_ctl_master_tb_top.sv
module phy_ctl_master_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, done, err;
    logic [15:0] rd_data;
    logic [31:0] ctl_word, stat_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_ctl_master dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .done      (done),
        .err       (err),
        .rd_data   (rd_data),
        .ctl_word  (ctl_word),
        .stat_word (stat_word)
    );

    // PHY responder model: acknowledge follows "any strobe" after lag cycles
    int          lag = 1;
    bit          stuck_hi = 1'b0;
    bit          deaf_wr = 1'b0;
    logic [15:0] phy_mem [16];
    logic [15:0] phy_addr = '0, phy_data = '0, phy_out = '0;
    logic [31:0] phy_prev = '0;
    logic [15:0] lag_sh = '0;
    logic        want, ack_m;

    always_comb begin
        want  = deaf_wr ? (ctl_word[19] | ctl_word[17] | ctl_word[16]) : (|ctl_word[19:16]);
        ack_m = stuck_hi ? 1'b1 : lag_sh[lag-1];
    end
    assign stat_word = {15'h0, ack_m, phy_out};

    always @(posedge clk) begin
        phy_prev <= ctl_word;
        lag_sh   <= {lag_sh[14:0], want};
        if (ctl_word[16] && !phy_prev[16]) phy_addr <= ctl_word[15:0];
        if (ctl_word[17] && !phy_prev[17]) phy_data <= ctl_word[15:0];
        if (ctl_word[18] && !phy_prev[18] && !deaf_wr) phy_mem[phy_addr[3:0]] <= phy_data;
        if (ctl_word[19] && !phy_prev[19]) phy_out <= phy_mem[phy_addr[3:0]];
    end

    // scoreboard
    typedef struct {
        bit          is_err;
        bit          is_rd;
        logic [15:0] rdata;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [15:0] shadow [16];
    logic [15:0] cur_addr = '0;
    int          n_chk = 0, n_bad = 0, n_evt = 0;
    logic        prev_done = 1'b0, prev_err = 1'b0;
    logic [31:0] prev_ctl = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (done || err) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected completion", {30'h0, done, err}, 32'h0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(err == e.is_err, {e.tag, " outcome err"}, {31'h0, err}, {31'h0, e.is_err});
                    if (!err && e.is_rd)
                        chk(rd_data == e.rdata, {e.tag, " read data"}, {16'h0, rd_data}, {16'h0, e.rdata});
                    if (err)
                        chk(ctl_word == 32'h0, "R8 control word zero on error", ctl_word, 32'h0);
                    chk(!(done && err), "R9 done and err exclusive", {30'h0, done, err}, 32'h0);
                end
                n_evt++;
            end
            if (prev_done || prev_err)
                chk(!(done || err), "R9 pulse length", {30'h0, done, err}, 32'h0);
            if (ctl_word[16:16] == 1'b1 && prev_ctl[16] == 1'b0)
                chk(ctl_word[15:0] == cur_addr, "R3 address with capture strobe",
                    {16'h0, ctl_word[15:0]}, {16'h0, cur_addr});
            if (|ctl_word[19:16])
                chk(($countones(ctl_word[19:16]) == 1) && (ctl_word[31:20] == 0),
                    "R2 single strobe", ctl_word, 32'h0);
            if (req_ready)
                chk(ctl_word == 32'h0, "R8 idle control word zero", ctl_word, 32'h0);
            prev_done = done;
            prev_err  = err;
            prev_ctl  = ctl_word;
        end
    end

    task automatic xfer(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        input bit exp_err, input string tag);
        exp_t e;
        int   start;
        e.is_err = exp_err;
        e.is_rd  = !wr;
        e.rdata  = shadow[a[3:0]];
        e.tag    = tag;
        sb_q.push_back(e);
        if (wr && !exp_err) shadow[a[3:0]] = d;
        start = n_evt;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cur_addr  = a;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (n_evt == start) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_evt, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] held;
        for (int i = 0; i < 16; i++) begin
            phy_mem[i] = '0;
            shadow[i]  = '0;
        end
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", {31'h0, req_ready}, 32'h1);
        chk(ctl_word == 32'h0, "R2 control word zero in reset", ctl_word, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !err, "R9 no pulse after reset", {30'h0, done, err}, 32'h0);

        lag = 1;
        xfer(1'b1, 16'h0001, 16'h1234, 1'b0, "R5 write lag1");
        xfer(1'b1, 16'h0002, 16'hBEEF, 1'b0, "R5 write lag1 b");
        xfer(1'b0, 16'h0001, 16'h0000, 1'b0, "R4 read lag1");
        xfer(1'b0, 16'h0002, 16'h0000, 1'b0, "R4 read lag1 b");

        lag = 3;
        xfer(1'b1, 16'h0007, 16'h0F0F, 1'b0, "R5 write lag3");
        xfer(1'b0, 16'h0007, 16'h0000, 1'b0, "R4 read lag3");
        xfer(1'b0, 16'h0000, 16'h0000, 1'b0, "R4 read untouched");

        // R1: request while busy is ignored
        lag = 2;
        fork
            xfer(1'b1, 16'h0003, 16'hAAAA, 1'b0, "R1 busy write");
            begin
                repeat (4) @(negedge clk);
                chk(req_ready == 1'b0, "R1 ready low while busy", {31'h0, req_ready}, 32'h0);
                req_valid = 1'b1;
                req_write = 1'b1;
                req_addr  = 16'h0004;
                req_wdata = 16'h5555;
                repeat (2) @(negedge clk);
                req_valid = 1'b0;
                req_addr  = 16'h0003;
            end
        join
        xfer(1'b0, 16'h0004, 16'h0000, 1'b0, "R1 ignored request left no write");
        xfer(1'b0, 16'h0003, 16'h0000, 1'b0, "R1 busy write landed");

        // R9: rd_data held across a write
        held = rd_data;
        xfer(1'b1, 16'h0009, 16'h1111, 1'b0, "R5 write hold test");
        chk(rd_data == held, "R9 rd_data held over write", {16'h0, rd_data}, {16'h0, held});

        // R7: ack on the tenth poll succeeds
        lag = 9;
        xfer(1'b1, 16'h0005, 16'hA5A5, 1'b0, "R7 write lag9");
        xfer(1'b0, 16'h0005, 16'h0000, 1'b0, "R7 read lag9");

        // R6/R8: one cycle late times out
        held = rd_data;
        lag = 10;
        xfer(1'b0, 16'h0005, 16'h0000, 1'b1, "R6 read lag10 timeout");
        chk(rd_data == held, "R9 rd_data held over error", {16'h0, rd_data}, {16'h0, held});
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(ctl_word == 32'h0 && req_ready, "R8 quiet after timeout", ctl_word, 32'h0);
        end
        lag = 1;
        repeat (20) @(negedge clk);

        // R8: acknowledge stuck high fails in the release wait
        stuck_hi = 1'b1;
        xfer(1'b1, 16'h0006, 16'h7777, 1'b1, "R8 stuck ack");
        stuck_hi = 1'b0;
        repeat (5) @(negedge clk);

        // R8: PHY ignores the write strobe, nothing is written
        deaf_wr = 1'b1;
        xfer(1'b1, 16'h0008, 16'h3333, 1'b1, "R8 write strobe unanswered");
        deaf_wr = 1'b0;
        repeat (5) @(negedge clk);
        xfer(1'b0, 16'h0008, 16'h0000, 1'b0, "R8 aborted write not applied");

        lag = 2;
        xfer(1'b0, 16'h0005, 16'h0000, 1'b0, "R4 read after recovery");

        repeat (5) @(negedge clk);
        chk(sb_q.size() == 0, "R9 all transfers completed", sb_q.size(), 32'h0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule